// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address and the base-register update for a single-word or single-byte load/store operation. The offset comes from one of two sources. The first is a 12-bit unsigned immediate. The second is a register value passed through a barrel shifter whose shift amount is a constant from the instruction. The block adds the offset to the base value or subtracts it from the base value. The pre/post-index flag then selects whether the access uses the offset address or the untouched base.

The address path and the writeback value are purely combinational. Writeback is requested when indexing is post-indexed or when the writeback flag is set. The request is a single-cycle strobe that follows a one-cycle execute pulse. When the base register is the program counter (index 15), the base reads as the instruction address plus 8. Any update to that base is sent to a dedicated PC-write strobe and does not go to the register file. The shifter takes the current carry flag as an input. No flag result leaves the block.

Top module: `ls_addr_gen`

## Requirements
- R1: With `imm_sel`=1 the offset is `imm_off` zero-extended to 32 bits. The register offset is then ignored.
- R2: With `imm_sel`=0 the offset is `rm_val` shifted by `shift_amt` (0..31). `shift_type` 00 is logical left. 01 is logical right, and an amount of 0 gives 0. 10 is arithmetic right, and an amount of 0 fills all bits with bit 31. 11 is rotate right, and an amount of 0 gives `{c_in, rm_val[31:1]}`.
- R3: With `base_idx`=15 the base value is `pc_val`+8 and `base_val` is ignored. With any other index the base value is `base_val`.
- R4: With `up`=1 the offset address is base+offset. With `up`=0 it is base−offset. Both are taken modulo 2^32.
- R5: With `pre`=1, `addr` is the offset address. With `pre`=0, `addr` is the unmodified base value.
- R6: When `exec_valid`=1 and (`pre`=0 or `wb`=1) and `base_idx`≠15, `wb_en`=1. In that case `wb_idx`=`base_idx` and `wb_val` is the offset address.
- R7: When `exec_valid`=1 and (`pre`=0 or `wb`=1) and `base_idx`=15, `pc_we`=1 and `wb_en`=0. `wb_val` carries the offset address. `wb_en` and `pc_we` are never high together.
- R8: When `exec_valid`=0, or when `pre`=1 with `wb`=0, both `wb_en` and `pc_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exec_valid | input | 1 | One-cycle execute pulse |
| base_idx | input | 4 | Base register index (15 = PC) |
| base_val | input | 32 | Base register value from register file |
| pc_val | input | 32 | Address of the current instruction |
| imm_sel | input | 1 | 1 = immediate offset, 0 = shifted register |
| imm_off | input | 12 | Unsigned immediate offset |
| rm_val | input | 32 | Offset register value |
| shift_type | input | 2 | Shift kind: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| shift_amt | input | 5 | Constant shift amount |
| c_in | input | 1 | Current carry flag (used by rotate-with-extend) |
| up | input | 1 | 1 = add offset, 0 = subtract |
| pre | input | 1 | 1 = pre-index, 0 = post-index |
| wb | input | 1 | Writeback request flag |
| addr | output | 32 | Access address |
| wb_en | output | 1 | Register-file writeback strobe |
| wb_idx | output | 4 | Writeback target index |
| wb_val | output | 32 | Writeback value (offset address) |
| pc_we | output | 1 | PC-write strobe for a PC base |

## Verification
The hardest case to reach is the set of zero-amount shift encodings. There, LSR and ASR behave as 32-bit shifts, and ROR becomes a one-bit rotate through carry whose result depends on `c_in`. The bench drives each of these with operands that have bit 31 and bit 0 set, once with the carry clear and once with it set. It combines these with a PC base and a sweep of all eight up/pre/writeback combinations. That sweep shows that the PC-write strobe replaces the register writeback and that the address switches between the base and the offset address.

// File: rtl/ls_addr_gen.sv
module ls_addr_gen #(
  parameter int XLEN     = 32,
  parameter int IMM_W    = 12,
  parameter int IDX_W    = 4,
  parameter int PC_AHEAD = 8
) (
  input  logic                     exec_valid,
  input  logic [IDX_W-1:0]         base_idx,
  input  logic [XLEN-1:0]          base_val,
  input  logic [XLEN-1:0]          pc_val,
  input  logic                     imm_sel,
  input  logic [IMM_W-1:0]         imm_off,
  input  logic [XLEN-1:0]          rm_val,
  input  logic [1:0]               shift_type,
  input  logic [$clog2(XLEN)-1:0]  shift_amt,
  input  logic                     c_in,
  input  logic                     up,
  input  logic                     pre,
  input  logic                     wb,
  output logic [XLEN-1:0]          addr,
  output logic                     wb_en,
  output logic [IDX_W-1:0]         wb_idx,
  output logic [XLEN-1:0]          wb_val,
  output logic                     pc_we
);
  localparam int SAW = $clog2(XLEN);
  localparam logic [IDX_W-1:0] PC_IDX = {IDX_W{1'b1}};

  logic [XLEN-1:0] sh_out, offset, base_eff, off_addr;
  logic [SAW-1:0]  ror_back;
  logic            is_pc, do_wb;

  assign ror_back = SAW'(0) - shift_amt;

  always_comb begin
    unique case (shift_type)
      2'b00: sh_out = rm_val << shift_amt;
      2'b01: sh_out = (shift_amt == '0) ? '0 : rm_val >> shift_amt;
      2'b10: sh_out = (shift_amt == '0) ? {XLEN{rm_val[XLEN-1]}}
                                        : XLEN'($signed(rm_val) >>> shift_amt);
      default: sh_out = (shift_amt == '0) ? {c_in, rm_val[XLEN-1:1]}
                                          : (rm_val >> shift_amt) | (rm_val << ror_back);
    endcase
  end

  assign offset   = imm_sel ? {{(XLEN-IMM_W){1'b0}}, imm_off} : sh_out;
  assign is_pc    = (base_idx == PC_IDX);
  assign base_eff = is_pc ? pc_val + XLEN'(PC_AHEAD) : base_val;
  assign off_addr = up ? base_eff + offset : base_eff - offset;
  assign addr     = pre ? off_addr : base_eff;
  assign do_wb    = exec_valid & (~pre | wb);
  assign wb_en    = do_wb & ~is_pc;
  assign pc_we    = do_wb & is_pc;
  assign wb_idx   = base_idx;
  assign wb_val   = off_addr;

  always_comb begin
    if (!$isunknown({exec_valid, base_idx, base_val, pc_val, imm_sel, imm_off,
                     rm_val, shift_type, shift_amt, c_in, up, pre, wb})) begin
      AST_IMM_RANGE: assert (!imm_sel || offset < (XLEN'(1) << IMM_W)); // R1
      AST_UPDOWN: assert ((up ? wb_val - base_eff : base_eff - wb_val) == offset); // R4
      AST_PRE_ADDR: assert (!pre || addr == wb_val); // R5
      AST_ONE_STROBE: assert ($onehot0({wb_en, pc_we})); // R7
      AST_PC_TARGET: assert (!pc_we || wb_idx == PC_IDX); // R7
      AST_IDLE_QUIET: assert (exec_valid || (!wb_en && !pc_we)); // R8
      AST_NO_WB_PRE: assert (!(pre && !wb) || (!wb_en && !pc_we)); // R8
    end
  end
endmodule

// File: tb/sim_ls_addr_gen.sv
module sim_ls_addr_gen;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        exec_valid = 0, imm_sel = 0, c_in = 0, up = 0, pre = 0, wb = 0;
  logic [3:0]  base_idx = 0;
  logic [31:0] base_val = 0, pc_val = 0, rm_val = 0;
  logic [11:0] imm_off = 0;
  logic [1:0]  shift_type = 0;
  logic [4:0]  shift_amt = 0;
  logic [31:0] addr, wb_val;
  logic        wb_en, pc_we;
  logic [3:0]  wb_idx;

  int n_chk = 0, n_bad = 0;

  ls_addr_gen u0 (.exec_valid, .base_idx, .base_val, .pc_val, .imm_sel, .imm_off,
                  .rm_val, .shift_type, .shift_amt, .c_in, .up, .pre, .wb,
                  .addr, .wb_en, .wb_idx, .wb_val, .pc_we);

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [31:0] m_shift(logic [31:0] v, logic [1:0] k, logic [4:0] a, logic c);
    logic [63:0] dbl;
    logic [31:0] r;
    case (k)
      2'd0: r = v << a;
      2'd1: r = (a == 0) ? 32'd0 : v >> a;
      2'd2: begin
        r = v;
        for (int i = 0; i < ((a == 0) ? 32 : int'(a)); i++) r = {v[31], r[31:1]};
      end
      default: begin
        if (a == 0) r = {c, v[31:1]};
        else begin dbl = {v, v} >> a; r = dbl[31:0]; end
      end
    endcase
    return r;
  endfunction

  task automatic apply_and_check(string req);
    logic [31:0] off, base, oa;
    logic dw;
    @(negedge clk);
    off  = imm_sel ? {20'd0, imm_off} : m_shift(rm_val, shift_type, shift_amt, c_in);
    base = (base_idx == 4'd15) ? pc_val + 32'd8 : base_val;
    oa   = up ? base + off : base - off;
    dw   = exec_valid && (!pre || wb);
    chk(req, "addr", addr, pre ? oa : base);
    chk(req, "wb_val", wb_val, oa);
    chk(req, "wb_en", {31'd0, wb_en}, {31'd0, dw && base_idx != 4'd15});
    chk(req, "pc_we", {31'd0, pc_we}, {31'd0, dw && base_idx == 4'd15});
    if (dw) chk(req, "wb_idx", {28'd0, wb_idx}, {28'd0, base_idx});
    @(posedge clk);
  endtask

  task automatic t_idle();
    exec_valid = 0; base_idx = 4'd3; base_val = 32'h1000; imm_sel = 1; imm_off = 12'h10;
    up = 1; pre = 0; wb = 1;
    @(negedge clk);
    chk("R8", "idle wb_en", {31'd0, wb_en}, 32'd0);
    chk("R8", "idle pc_we", {31'd0, pc_we}, 32'd0);
    @(posedge clk);
  endtask

  task automatic t_immediate();
    exec_valid = 1; imm_sel = 1; base_idx = 4'd2; base_val = 32'h0000_2000;
    up = 1; pre = 1; wb = 0; rm_val = 32'hFFFF_FFFF;
    imm_off = 12'hFFF;
    apply_and_check("R1");
    @(negedge clk);
    chk("R1", "zero-extended max imm", addr, 32'h0000_2FFF);
    chk("R8", "pre no wb", {31'd0, wb_en}, 32'd0);
    imm_off = 12'h001; up = 0;
    apply_and_check("R1");
    @(negedge clk);
    chk("R4", "subtract", addr, 32'h0000_1FFF);
  endtask

  task automatic t_shifts();
    exec_valid = 1; imm_sel = 0; base_idx = 4'd5; base_val = 32'h8000_0000;
    up = 1; pre = 1; wb = 1;
    foreach (rm_val[i]) begin end
    for (int k = 0; k < 4; k++) begin
      for (int a = 0; a < 32; a += 7) begin
        for (int c = 0; c < 2; c++) begin
          shift_type = 2'(k); shift_amt = 5'(a); c_in = c[0];
          rm_val = 32'h8000_0001 ^ (32'h0F0F_1234 * 32'(a + 1));
          apply_and_check("R2");
        end
      end
    end
    shift_type = 2'd3; shift_amt = 0; rm_val = 32'h8000_0001; base_val = 0; pre = 1; up = 1;
    c_in = 1; @(negedge clk); chk("R2", "rrx carry set", addr, 32'hC000_0000);
    c_in = 0; @(negedge clk); chk("R2", "rrx carry clear", addr, 32'h4000_0000);
    shift_type = 2'd2; @(negedge clk); chk("R2", "asr #32", addr, 32'hFFFF_FFFF);
    shift_type = 2'd1; @(negedge clk); chk("R2", "lsr #32", addr, 32'h0000_0000);
    shift_type = 2'd0; @(negedge clk); chk("R2", "lsl #0", addr, 32'h8000_0001);
    @(posedge clk);
  endtask

  task automatic t_pc_base();
    exec_valid = 1; imm_sel = 1; imm_off = 12'h004; base_idx = 4'd15;
    base_val = 32'hDEAD_BEEF; pc_val = 32'h0000_0100; up = 1; pre = 0; wb = 0;
    apply_and_check("R3");
    @(negedge clk);
    chk("R3", "pc base +8", addr, 32'h0000_0108);
    chk("R7", "pc strobe", {31'd0, pc_we}, 32'd1);
    chk("R7", "no rf wb", {31'd0, wb_en}, 32'd0);
    chk("R7", "pc wb value", wb_val, 32'h0000_010C);
    @(posedge clk);
  endtask

  task automatic t_sweep();
    for (int b = 0; b < 2; b++) begin
      for (int f = 0; f < 8; f++) begin
        exec_valid = 1; imm_sel = f[0]; imm_off = 12'h234; rm_val = 32'h0000_0040;
        shift_type = 2'd0; shift_amt = 5'd2;
        base_idx = b[0] ? 4'd15 : 4'd14; base_val = 32'h0001_0000; pc_val = 32'h0000_8000;
        up = f[0]; pre = f[1]; wb = f[2];
        apply_and_check(b[0] ? "R7" : "R6");
      end
    end
  endtask

  task automatic t_wrap();
    exec_valid = 1; imm_sel = 1; base_idx = 4'd0; pre = 1; wb = 1;
    base_val = 32'hFFFF_FFF0; imm_off = 12'h020; up = 1;
    apply_and_check("R4");
    @(negedge clk); chk("R4", "add wrap", wb_val, 32'h0000_0010);
    base_val = 32'h0000_0008; up = 0;
    apply_and_check("R4");
    @(negedge clk); chk("R4", "sub wrap", wb_val, 32'hFFFF_FFE8);
    chk("R5", "pre addr", addr, 32'hFFFF_FFE8);
    pre = 0;
    @(negedge clk); chk("R5", "post addr", addr, 32'h0000_0008);
    chk("R6", "post wb", {31'd0, wb_en}, 32'd1);
    exec_valid = 0;
    @(negedge clk); chk("R8", "no pulse", {31'd0, wb_en}, 32'd0);
    @(posedge clk);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_idle();
    t_immediate();
    t_shifts();
    t_pc_base();
    t_sweep();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule